// File: doc/BRIEF.md
# Comma Word Aligner

This block sits after a deserializer. Each clock cycle it takes one 10-bit slice of a received serial stream and looks for an 8b/10b comma at every bit offset of a two-word window. The window holds the current slice and the previous one. When it finds a comma, it moves the word boundary so that the comma becomes a whole output word. It then presents each aligned word with a one-word comma flag and a pair of half-rate strobes that are in opposite phase. The strobes let a protocol engine capture even-numbered and odd-numbered words on separate edges.

Alignment is governed by two controls. `lock_ok` comes from the receiver lock sequencer and gates all activity. `align_en` permits realignment at any time. When `align_en` is low, the block still performs one initial alignment if no comma has ever reached the boundary. After that, while `align_en` stays low, it ignores commas that sit off the boundary.

Top module: `word_aligner`

## Requirements
- R1: A comma is recognised from bits 0..6 of a candidate word, where bit 0 is the earliest bit. The pattern is 0,0,1,1,1,1,1 or its complement 1,1,0,0,0,0,0. This covers K28.1, K28.5 and K28.7 in both running disparities. As 10-bit values with bit 0 as the LSB, these are K28.5 = 0x17C/0x283, K28.1 = 0x27C and K28.7 = 0x07C.
- R2: Assume `lock_ok`=1 and `align_en`=1, and a comma starts at bit s (s in 0..9) of raw slice m. The word presented after the clock edge that captures slice m+1 is that comma. Every later word starts s bits into its slice. The straddling word on the old boundary is dropped.
- R3: `comma_out` is 1 for exactly those presented words that are commas per R1, whatever the value of `align_en`.
- R4: Assume `align_en`=0 and a comma has already been on the boundary. A comma off the boundary then leaves the boundary unchanged, and `comma_out` stays 0.
- R5: Assume `align_en`=0 and no comma has yet been on the boundary since reset. The first comma is aligned as in R2. Later commas off the boundary are treated as in R4.
- R6: Bit 0 of a raw slice is the earliest serial bit. With boundary offset b, the word presented after edge n is {slice n, slice n-1}[b+9:b]. At reset the offset is 0.
- R7: `strobe_a` is 1 while an even-numbered word (0, 2, …) is presented. `strobe_b` is always its inverse. Both change once per presented word. At reset `strobe_a`=0 and `strobe_b`=1.
- R8: While `lock_ok`=0 the block detects nothing and keeps its boundary. `word_out` holds, `comma_out` is 0, and the strobes hold, which stretches them.
- R9: Reset clears `word_out` to 0 and `comma_out` to 0, and clears the alignment history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_ok | input | 1 | Receiver locked; enables detection and output |
| align_en | input | 1 | Allow realignment on any off-boundary comma |
| raw_word | input | 10 | Raw deserialized slice, bit 0 earliest |
| word_out | output | 10 | Aligned word |
| comma_out | output | 1 | Presented word is a comma |
| strobe_a | output | 1 | High during even-numbered words |
| strobe_b | output | 1 | Inverse of strobe_a |

## Verification
The bench targets four areas:
- Commas at several offsets, in both disparities and all three comma codes. A wrong shift direction or a one-cycle switch error shows up as garbled words right after the comma.
- The disabled-alignment history. A design that forgets whether alignment happened would either realign on a second comma or refuse the first one, and the word stream then breaks at the wrong place.
- Lock low. A design that keeps scanning while unlocked would take on a boundary from a comma it was meant to ignore.
- The strobes. Strobes that advance during hold cycles would put even and odd words on the wrong capture edge.

// File: rtl/wa_pkg.sv
`timescale 1ns/1ps
package wa_pkg;
   // comma prefix, listed with the earliest serial bit in position 0
   localparam int unsigned WA_PFX_W = 7;
   localparam logic [WA_PFX_W-1:0] WA_PFX_MINUS = 7'b1111100;
   localparam logic [WA_PFX_W-1:0] WA_PFX_PLUS  = 7'b0000011;
endpackage

// File: rtl/wa_comma_scan.sv
`timescale 1ns/1ps
module wa_comma_scan #(
   parameter int unsigned SYM_W   = 10,
   parameter int unsigned PFX_W   = 7,
   parameter bit          BOTH_RD = 1'b1,
   parameter logic [PFX_W-1:0] PAT_MINUS = '0,
   parameter logic [PFX_W-1:0] PAT_PLUS  = '1
) (
   input  logic [2*SYM_W-1:0] window,
   output logic [SYM_W-1:0]   hits
);
   for (genvar k = 0; k < SYM_W; k++) begin : g_off
      logic [PFX_W-1:0] slice;
      assign slice = window[k +: PFX_W];
      if (BOTH_RD) begin : g_both
         assign hits[k] = (slice == PAT_MINUS) || (slice == PAT_PLUS);
      end else begin : g_minus
         assign hits[k] = (slice == PAT_MINUS);
      end
   end
endmodule

// File: rtl/wa_boundary_ctl.sv
`timescale 1ns/1ps
module wa_boundary_ctl #(
   parameter int unsigned SYM_W = 10,
   parameter int unsigned SEL_W = $clog2(SYM_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_ok,
   input  logic             align_en,
   input  logic [SYM_W-1:0] hits,
   output logic [SEL_W-1:0] use_sel,
   output logic             bnd_hit
);
   logic [SEL_W-1:0] sel_q, pick;
   logic any, ever_q, on_bnd, realign;

   // lowest offset wins when several offsets match
   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int k = SYM_W - 1; k >= 0; k--) begin
         if (hits[k]) begin
            pick = SEL_W'(k);
            any  = 1'b1;
         end
      end
   end

   assign on_bnd  = hits[sel_q];
   assign realign = lock_ok & any & ~on_bnd & (align_en | ~ever_q);
   assign use_sel = realign ? pick : sel_q;
   assign bnd_hit = lock_ok & (on_bnd | realign);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q  <= '0;
         ever_q <= 1'b0;
      end else begin
         sel_q  <= use_sel;
         ever_q <= ever_q | bnd_hit;
      end
   end

   assert_keep_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_ok && !align_en && ever_q && !hits[sel_q]) |=> (sel_q == $past(sel_q)));
   assert_first_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_ok && !ever_q && any) |=> ever_q);
   assert_history_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ever_q |=> ever_q);
   assert_idle_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_ok |=> $stable(sel_q));
endmodule

// File: rtl/wa_strobe_gen.sv
`timescale 1ns/1ps
module wa_strobe_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   output logic strobe_a,
   output logic strobe_b
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_a <= 1'b0;
         strobe_b <= 1'b1;
      end else if (step) begin
         strobe_a <= ~strobe_a;
         strobe_b <= strobe_a;
      end
   end

   assert_opposite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_a != strobe_b);
   assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (strobe_a != $past(strobe_a)));
   assert_stretch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(strobe_a));
endmodule

// File: rtl/word_aligner.sv
`timescale 1ns/1ps
module word_aligner
   import wa_pkg::*;
#(
   parameter int unsigned SYM_W   = 10,
   parameter int unsigned PFX_W   = WA_PFX_W,
   parameter bit          BOTH_RD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_ok,
   input  logic             align_en,
   input  logic [SYM_W-1:0] raw_word,
   output logic [SYM_W-1:0] word_out,
   output logic             comma_out,
   output logic             strobe_a,
   output logic             strobe_b
);
   localparam int unsigned WIN_W = 2 * SYM_W;
   localparam int unsigned SEL_W = $clog2(SYM_W);

   if (PFX_W != WA_PFX_W || SYM_W <= PFX_W) begin : g_bad_cfg
      $error("word_aligner: prefix width must be %0d and below SYM_W", WA_PFX_W);
   end

   logic [SYM_W-1:0] prev_q;
   logic [WIN_W-1:0] window;
   logic [SYM_W-1:0] hits;
   logic [SEL_W-1:0] use_sel;
   logic             bnd_hit;

   assign window = {raw_word, prev_q};

   wa_comma_scan #(
      .SYM_W(SYM_W), .PFX_W(PFX_W), .BOTH_RD(BOTH_RD),
      .PAT_MINUS(WA_PFX_MINUS), .PAT_PLUS(WA_PFX_PLUS)
   ) scan_i (
      .window(window),
      .hits  (hits)
   );

   wa_boundary_ctl #(.SYM_W(SYM_W), .SEL_W(SEL_W)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_ok (lock_ok),
      .align_en(align_en),
      .hits    (hits),
      .use_sel (use_sel),
      .bnd_hit (bnd_hit)
   );

   wa_strobe_gen strb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (lock_ok),
      .strobe_a(strobe_a),
      .strobe_b(strobe_b)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q    <= '0;
         word_out  <= '0;
         comma_out <= 1'b0;
      end else begin
         prev_q    <= raw_word;
         comma_out <= bnd_hit;
         if (lock_ok) begin
            word_out <= window[use_sel +: SYM_W];
         end
      end
   end

   assert_flag_means_comma_R3: assert property (@(posedge clk) disable iff (!rst_n)
      comma_out |-> (word_out[PFX_W-1:0] == WA_PFX_MINUS || word_out[PFX_W-1:0] == WA_PFX_PLUS));
   assert_hold_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_ok |=> ($stable(word_out) && !comma_out));
endmodule

// File: tb/word_aligner_tb_top.sv
`timescale 1ns/1ps
module word_aligner_tb_top;
   localparam logic [9:0] K5N = 10'h17C, K5P = 10'h283, K1N = 10'h27C, K7N = 10'h07C;
   localparam logic [9:0] D1 = 10'h155, D2 = 10'h2AA, D3 = 10'h1A5, D4 = 10'h25A;

   logic clk = 1'b0, rst_n = 1'b0, lock_ok = 1'b0, align_en = 1'b0;
   logic [9:0] raw_word = '0;
   logic [9:0] word_out;
   logic comma_out, strobe_a, strobe_b;

   always #2.5 clk = ~clk;

   word_aligner dut_i (
      .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .align_en(align_en),
      .raw_word(raw_word), .word_out(word_out), .comma_out(comma_out),
      .strobe_a(strobe_a), .strobe_b(strobe_b)
   );

   typedef struct {
      logic [9:0] w;
      logic       f;
      logic       sa;
      string      tag;
   } exp_t;

   exp_t expq[$];
   bit   sq[$];
   bit   fill_ph = 1'b1;
   int   checks = 0, errors = 0;
   logic [9:0] prev_w = '0, last_w = '0;
   int   exp_b = 0;
   logic exp_sa = 1'b0;

   function automatic logic is_comma(input logic [9:0] v);
      return (v[6:0] == 7'b1111100) || (v[6:0] == 7'b0000011);
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic push_sym(input logic [9:0] v);
      for (int i = 0; i < 10; i++) sq.push_back(v[i]);
   endtask

   task automatic push_fill(input int n);
      for (int i = 0; i < n; i++) begin
         sq.push_back(fill_ph);
         fill_ph = ~fill_ph;
      end
   endtask

   // driver: one raw slice per cycle, expected result pushed for the coming edge
   task automatic run(input int nwords, input bit lk, input bit al,
                      input int sw, input int nb, input string tag);
      for (int c = 0; c < nwords; c++) begin
         logic [9:0]  cur;
         logic [19:0] win;
         exp_t        it;
         @(negedge clk);
         lock_ok  = lk;
         align_en = al;
         for (int i = 0; i < 10; i++) begin
            if (sq.size() > 0) cur[i] = sq.pop_front();
            else begin
               cur[i]  = fill_ph;
               fill_ph = ~fill_ph;
            end
         end
         if (c == sw) exp_b = nb;
         if (lk) begin
            win    = {cur, prev_w};
            last_w = win[exp_b +: 10];
            exp_sa = ~exp_sa;
            it.f   = is_comma(last_w);
         end else begin
            it.f = 1'b0;
         end
         it.w   = last_w;
         it.sa  = exp_sa;
         it.tag = tag;
         expq.push_back(it);
         raw_word = cur;
         prev_w   = cur;
      end
   endtask

   task automatic reset_dut();
      @(negedge clk);
      lock_ok  = 1'b0;
      align_en = 1'b0;
      raw_word = '0;
      rst_n    = 1'b0;
      repeat (3) @(negedge clk);
      chk(word_out == 10'h000, "R9", "reset word", word_out, 10'h000);
      chk(comma_out == 1'b0, "R9", "reset flag", {9'b0, comma_out}, 10'h000);
      chk(strobe_a == 1'b0 && strobe_b == 1'b1, "R7", "reset strobes",
          {8'b0, strobe_a, strobe_b}, 10'h001);
      rst_n  = 1'b1;
      prev_w = '0;
      last_w = '0;
      exp_b  = 0;
      exp_sa = 1'b0;
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         exp_t it;
         @(posedge clk);
         #1;
         if (expq.size() > 0) begin
            it = expq.pop_front();
            chk(word_out == it.w, it.tag, "word", word_out, it.w);
            chk(comma_out == it.f, {it.tag, " R3"}, "comma flag",
                {9'b0, comma_out}, {9'b0, it.f});
            chk(strobe_a == it.sa && strobe_b == ~it.sa, {it.tag, " R7"}, "strobes",
                {8'b0, strobe_a, strobe_b}, {8'b0, it.sa, ~it.sa});
         end
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      reset_dut();
      // R8: a comma arriving while unlocked is not acted on
      sq.delete(); push_fill(13); push_sym(K5N); push_sym(D1);
      run(6, 1'b0, 1'b1, -1, 0, "R8 unlocked hold");
      // R2/R1/R6: align to offset 3, then a plus-disparity comma on the boundary
      sq.delete(); push_fill(23);
      push_sym(K5N); push_sym(D1); push_sym(D3); push_sym(D4); push_sym(D2);
      push_sym(K5P); push_sym(D1);
      run(10, 1'b1, 1'b1, 3, 3, "R1 R2 R6 offset3");
      // R2/R1: realign to offset 7 with K28.7, then K28.1 on the boundary
      sq.delete(); push_fill(17); push_sym(K7N); push_sym(D3); push_sym(K1N); push_sym(D1);
      run(6, 1'b1, 1'b1, 2, 7, "R1 R2 R6 offset7");
      // R4: alignment disabled after alignment: misaligned comma ignored
      sq.delete(); push_fill(12); push_sym(K5N); push_sym(D1); push_sym(D4);
      run(5, 1'b1, 1'b0, -1, 0, "R4 misaligned ignored");
      // R3: aligned comma still flagged while disabled
      sq.delete(); push_fill(7); push_sym(K5N); push_sym(D1);
      run(3, 1'b1, 1'b0, -1, 0, "R3 R4 aligned while disabled");
      // R5: fresh history, alignment disabled: first comma aligned
      reset_dut();
      sq.delete(); push_fill(25); push_sym(K5N); push_sym(D3); push_sym(D1);
      run(6, 1'b1, 1'b0, 3, 5, "R5 first comma aligned");
      sq.delete(); push_fill(11); push_sym(K5P); push_sym(D1);
      run(4, 1'b1, 1'b0, -1, 0, "R5 only the first");
      // R2: enabling again realigns
      sq.delete(); push_fill(11); push_sym(K5P); push_sym(D2);
      run(4, 1'b1, 1'b1, 2, 1, "R2 re-enabled offset1");
      // R8: unlocked comma must not move the boundary
      sq.delete(); push_fill(14); push_sym(K5N);
      run(4, 1'b0, 1'b1, -1, 0, "R8 no detect unlocked");
      sq.delete();
      run(3, 1'b1, 1'b1, -1, 0, "R8 boundary kept");
      @(negedge clk);
      lock_ok = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule